// File: doc/BRIEF.md
# Four-Mode Cascadable Timer/Counter

This block is a 16-bit timer/counter made of two 8-bit halves. A fixed 2-bit prescaler divides the instruction-cycle tick by four. Its output drives an 8-bit programmable prescaler, and the programmable prescaler divides again by its reload value plus one. A 2-bit mode field selects one of four arrangements of the halves:
- two separate 8-bit timers;
- an 8-bit timer beside an 8-bit counter of external events;
- one 16-bit timer;
- one 16-bit event counter.

Each half counts up to its own programmed match value. On the next count it returns to zero and raises a one-cycle interrupt pulse.

A register write port loads the mode, the prescaler reload value and the two match values. The external event input is asynchronous. It passes through a synchronizer and is sampled only on instruction-cycle ticks, so an event level must last at least one instruction cycle to be seen. Every count and every event sample happens on a tick, so all timing is in whole instruction cycles.

Top module: `tc_quad_timer`

## Requirements
- R1: While `rst` is high, and after it is released before any count, `cnt_lo`, `cnt_hi`, `irq_lo` and `irq_hi` are all zero.
- R2: In a timer arrangement a half advances once every 4*(P+1) ticks, where P is the prescaler reload value. The counts never change in a clock cycle where `tick` is low.
- R3: Mode code 0 makes both halves independent prescaled timers. The low half pulses `irq_lo` every (ML+1) advances and the high half pulses `irq_hi` every (MH+1) advances.
- R4: Mode code 1 makes the low half a prescaled timer and the high half a counter of external event rising edges. The high half pulses `irq_hi` every (MH+1) events.
- R5: Mode code 2 makes one prescaled 16-bit timer {cnt_hi,cnt_lo}. The low byte carries into the high byte, `irq_hi` pulses every ({MH,ML}+1) advances, and `irq_lo` stays low.
- R6: Mode code 3 makes one 16-bit counter of external events. It ignores the prescaler and pulses `irq_hi` every ({MH,ML}+1) events.
- R7: The event level is sampled only on ticks, after a two-stage synchronizer. A pulse that no tick sample sees is not counted. Each low-to-high change between samples counts exactly once.
- R8: When a half, or the 16-bit pair, advances while equal to its match value, it goes to zero. Its interrupt output is high for exactly that one clock cycle.
- R9: A write with `wr_sel`=0 (mode in `wr_data[1:0]`) clears both counts, both prescalers and both interrupt outputs. Writes with `wr_sel`=1 (prescaler reload), 2 (low match) or 3 (high match) leave the counts unchanged.
- R10: In modes 0 and 2, activity on `evt_in` has no effect on either count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle instruction-cycle pulse |
| evt_in | input | 1 | Asynchronous external event level |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 mode, 1 prescaler reload, 2 low match, 3 high match |
| wr_data | input | 8 | Write data |
| cnt_lo | output | 8 | Low half count |
| cnt_hi | output | 8 | High half count |
| irq_lo | output | 1 | Low half interrupt pulse |
| irq_hi | output | 1 | High half interrupt pulse |

## Verification
The hardest case to reach from the ports is an event pulse that the synchronizer catches but that no tick sample sees. To produce it, the stimulus slows the tick to one in eight clocks. It aligns to a tick at a clock edge and then raises `evt_in` for a single clock just after that tick. The count must stay at zero. The same setup then gives longer pulses, each of which must count once. The 16-bit carry is reached by running the wide timer with match 0x01FF and reading both bytes just before and just after the 256th advance.

// File: rtl/tc_pkg.sv
package tc_pkg;
  typedef enum logic [1:0] {
    TM_SPLIT      = 2'd0,
    TM_TIMER_EVT  = 2'd1,
    TM_WIDE_TIMER = 2'd2,
    TM_WIDE_EVT   = 2'd3
  } tc_mode_e;

  localparam logic [1:0] SEL_MODE   = 2'd0;
  localparam logic [1:0] SEL_PRE    = 2'd1;
  localparam logic [1:0] SEL_MATCHL = 2'd2;
  localparam logic [1:0] SEL_MATCHH = 2'd3;
endpackage

// File: rtl/tc_prescale.sv
module tc_prescale #(
  parameter int FIX_BITS = 2,
  parameter int PRE_BITS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                tick,
  input  logic [PRE_BITS-1:0] reload,
  output logic                pre_out
);
  logic [FIX_BITS-1:0] fix_q;
  logic [PRE_BITS-1:0] pcnt_q;
  logic                fix_wrap;

  assign fix_wrap = tick && (&fix_q);
  assign pre_out  = fix_wrap && (pcnt_q >= reload);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      fix_q  <= '0;
      pcnt_q <= '0;
    end else begin
      if (tick) fix_q <= fix_q + 1'b1;
      if (fix_wrap) begin
        if (pcnt_q >= reload) pcnt_q <= '0;
        else                  pcnt_q <= pcnt_q + 1'b1;
      end
    end
  end

  // R2: the fixed stage only moves on a tick
  p_fix_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!tick && !clr) |=> $stable(fix_q));
  // R2: the programmable stage only moves when the fixed stage wraps
  p_pcnt_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!fix_wrap && !clr) |=> $stable(pcnt_q));
endmodule

// File: rtl/tc_event_sync.sv
module tc_event_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic evt_in,
  output logic evt_edge
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   samp_q;
  logic                   evt_s;

  assign evt_s    = sync_q[SYNC_STAGES-1];
  assign evt_edge = tick && evt_s && !samp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      samp_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], evt_in};
      if (tick) samp_q <= evt_s;
    end
  end

  // R7: one level change yields a single count
  p_edge_once_r7: assert property (@(posedge clk) disable iff (rst)
    evt_edge |=> !evt_edge);
  // R7: the sampled level only changes on a tick
  p_samp_on_tick_r7: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(samp_q));
endmodule

// File: rtl/tc_core.sv
module tc_core
  import tc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  tc_mode_e     mode,
  input  logic         adv_pre,
  input  logic         adv_evt,
  input  logic [W-1:0] match_lo,
  input  logic [W-1:0] match_hi,
  output logic [W-1:0] cnt_lo,
  output logic [W-1:0] cnt_hi,
  output logic         irq_lo,
  output logic         irq_hi
);
  logic           wide;
  logic           adv_lo;
  logic           adv_hi;
  logic [2*W-1:0] pair;
  logic [2*W-1:0] pair_nxt;

  assign wide     = (mode == TM_WIDE_TIMER) || (mode == TM_WIDE_EVT);
  assign adv_lo   = (mode == TM_WIDE_EVT)  ? adv_evt : adv_pre;
  assign adv_hi   = (mode == TM_TIMER_EVT) ? adv_evt : adv_pre;
  assign pair     = {cnt_hi, cnt_lo};
  assign pair_nxt = pair + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_lo <= '0;
      cnt_hi <= '0;
      irq_lo <= 1'b0;
      irq_hi <= 1'b0;
    end else begin
      irq_lo <= 1'b0;
      irq_hi <= 1'b0;
      if (wide) begin
        if (adv_lo) begin
          if (pair == {match_hi, match_lo}) begin
            cnt_lo <= '0;
            cnt_hi <= '0;
            irq_hi <= 1'b1;
          end else begin
            {cnt_hi, cnt_lo} <= pair_nxt;
          end
        end
      end else begin
        if (adv_lo) begin
          if (cnt_lo == match_lo) begin
            cnt_lo <= '0;
            irq_lo <= 1'b1;
          end else begin
            cnt_lo <= cnt_lo + 1'b1;
          end
        end
        if (adv_hi) begin
          if (cnt_hi == match_hi) begin
            cnt_hi <= '0;
            irq_hi <= 1'b1;
          end else begin
            cnt_hi <= cnt_hi + 1'b1;
          end
        end
      end
    end
  end

  // R8: interrupt pulses last one cycle
  p_lo_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    irq_lo |=> !irq_lo);
  p_hi_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    irq_hi |=> !irq_hi);
  // R8: a pulse always comes with a half that has returned to zero
  p_lo_wrap_zero_r8: assert property (@(posedge clk) disable iff (rst)
    irq_lo |-> (cnt_lo == '0));
  // R2: without any advance the counts hold
  p_stall_r2: assert property (@(posedge clk) disable iff (rst)
    (!adv_pre && !adv_evt && !clr) |=> ($stable(cnt_lo) && $stable(cnt_hi)));
endmodule

// File: rtl/tc_quad_timer.sv
module tc_quad_timer
  import tc_pkg::*;
#(
  parameter int W           = 8,
  parameter int FIX_BITS    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         evt_in,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] cnt_lo,
  output logic [W-1:0] cnt_hi,
  output logic         irq_lo,
  output logic         irq_hi
);
  tc_mode_e     mode_q;
  logic [W-1:0] pre_q;
  logic [W-1:0] mlo_q;
  logic [W-1:0] mhi_q;
  logic         mode_wr;
  logic         pre_tick;
  logic         evt_edge;
  logic         unused_mode_bits;

  assign mode_wr          = wr_en && (wr_sel == SEL_MODE);
  assign unused_mode_bits = ^wr_data[W-1:2];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= TM_SPLIT;
      pre_q  <= '0;
      mlo_q  <= '1;
      mhi_q  <= '1;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_MODE:   mode_q <= tc_mode_e'(wr_data[1:0]);
        SEL_PRE:    pre_q  <= wr_data;
        SEL_MATCHL: mlo_q  <= wr_data;
        default:    mhi_q  <= wr_data;
      endcase
    end
  end

  tc_prescale #(.FIX_BITS(FIX_BITS), .PRE_BITS(W)) u_pre (
    .clk(clk), .rst(rst), .clr(mode_wr), .tick(tick),
    .reload(pre_q), .pre_out(pre_tick)
  );

  tc_event_sync #(.SYNC_STAGES(SYNC_STAGES)) u_evt (
    .clk(clk), .rst(rst), .tick(tick), .evt_in(evt_in), .evt_edge(evt_edge)
  );

  tc_core #(.W(W)) u_core (
    .clk(clk), .rst(rst), .clr(mode_wr), .mode(mode_q),
    .adv_pre(pre_tick), .adv_evt(evt_edge),
    .match_lo(mlo_q), .match_hi(mhi_q),
    .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  // R9: a mode write leaves both halves at zero
  p_mode_clear_r9: assert property (@(posedge clk) disable iff (rst)
    mode_wr |=> (cnt_lo == '0 && cnt_hi == '0 && !irq_lo && !irq_hi));
  // R5: the wide arrangements never raise the low interrupt
  p_wide_lo_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (mode_q == TM_WIDE_TIMER || mode_q == TM_WIDE_EVT) |-> !irq_lo);
endmodule

// File: tb/tb_tc_quad_timer.sv
`timescale 1ns/1ps
module tb_tc_quad_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b0;
  logic       tick;
  logic       evt_in = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] cnt_lo, cnt_hi;
  logic       irq_lo, irq_hi;

  int checks = 0;
  int fails = 0;
  int tick_per = 1;
  int ph = 0;
  bit evt_auto = 1'b0;
  int ecnt = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  assign tick = tick_en && (ph == 0);

  tc_quad_timer dut (
    .clk(clk), .rst(rst), .tick(tick), .evt_in(evt_in),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  initial forever begin
    @(negedge clk);
    if (ph >= tick_per - 1) ph = 0;
    else ph = ph + 1;
  end

  initial forever begin
    @(negedge clk);
    if (evt_auto) begin
      ecnt = ecnt + 1;
      if (ecnt == 3) begin
        evt_in = ~evt_in;
        ecnt = 0;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic setup(int mode, int pr, int mlo, int mhi);
    wr(2'd1, 8'(pr));
    wr(2'd2, 8'(mlo));
    wr(2'd3, 8'(mhi));
    wr(2'd0, 8'(mode));
  endtask

  // mode, prescale, match lo, match hi, lo period (0 none), hi period, lo first checked, hi first checked
  localparam int NV = 5;
  localparam int VEC [NV][8] = '{
    '{0, 0, 2, 5,  12,   24, 1, 1},
    '{0, 2, 1, 0,  24,   12, 1, 1},
    '{1, 1, 3, 2,  32,   18, 1, 0},
    '{2, 0, 3, 1,   0, 1040, 0, 1},
    '{3, 9, 4, 0,   0,   30, 0, 0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int snap;
    repeat (3) @(negedge clk);
    chk("R1 reset cnt_lo", cnt_lo, 0);
    chk("R1 reset cnt_hi", cnt_hi, 0);
    chk("R1 reset irqs", {irq_hi, irq_lo}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after release", {cnt_hi, cnt_lo, 6'b0, irq_hi, irq_lo}, 0);

    // vector table
    tick_en = 1'b1; tick_per = 1; evt_auto = 1'b1;
    for (int v = 0; v < NV; v++) begin
      int lo_n, hi_n, lo_t1, lo_t2, hi_t1, hi_t2, win;
      string tag;
      lo_n = 0; hi_n = 0; lo_t1 = 0; lo_t2 = 0; hi_t1 = 0; hi_t2 = 0;
      win = 2 * ((VEC[v][4] > VEC[v][5]) ? VEC[v][4] : VEC[v][5]) + 40;
      case (VEC[v][0])
        0: tag = "R3 R8 R10 split";
        1: tag = "R4 R8 timer+events";
        2: tag = "R5 R10 wide timer";
        default: tag = "R6 wide events";
      endcase
      setup(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);
      for (int n = 1; n <= win; n++) begin
        @(negedge clk);
        if (irq_lo) begin
          lo_n++;
          if (lo_n == 1) lo_t1 = n; else if (lo_n == 2) lo_t2 = n;
        end
        if (irq_hi) begin
          hi_n++;
          if (hi_n == 1) hi_t1 = n; else if (hi_n == 2) hi_t2 = n;
        end
      end
      if (VEC[v][4] == 0) chk({tag, " lo silent"}, lo_n, 0);
      else begin
        chk({tag, " lo period"}, lo_t2 - lo_t1, VEC[v][4]);
        if (VEC[v][6] != 0) chk({tag, " lo first"}, lo_t1, VEC[v][4]);
      end
      chk({tag, " hi period"}, hi_t2 - hi_t1, VEC[v][5]);
      if (VEC[v][7] != 0) chk({tag, " hi first"}, hi_t1, VEC[v][5]);
    end

    // R2: advance every 4*(P+1) ticks
    evt_auto = 1'b0; evt_in = 1'b0;
    setup(0, 0, 200, 200);
    repeat (43) @(negedge clk);
    chk("R2 cnt_lo before 11th advance", cnt_lo, 10);
    @(negedge clk);
    chk("R2 cnt_lo at 11th advance", cnt_lo, 11);
    chk("R2 cnt_hi at 11th advance", cnt_hi, 11);

    // R2: no tick, no count
    tick_en = 1'b0;
    snap = cnt_lo;
    repeat (30) @(negedge clk);
    chk("R2 hold without tick", cnt_lo, snap);

    // R9: match/prescale writes keep counts, mode write clears
    wr(2'd2, 8'd50);
    wr(2'd1, 8'd3);
    chk("R9 match write keeps count", cnt_lo, snap);
    wr(2'd0, 8'd0);
    chk("R9 mode write clears", {cnt_hi, cnt_lo}, 0);

    // R10: events ignored in split mode
    tick_en = 1'b1; tick_per = 1;
    setup(0, 255, 10, 10);
    evt_auto = 1'b1;
    repeat (100) @(negedge clk);
    chk("R10 events ignored mode0", {cnt_hi, cnt_lo}, 0);
    setup(2, 255, 10, 10);
    repeat (100) @(negedge clk);
    chk("R10 events ignored mode2", {cnt_hi, cnt_lo}, 0);
    evt_auto = 1'b0; evt_in = 1'b0;

    // R5: low byte carries into high byte
    setup(2, 0, 8'hFF, 8'h01);
    repeat (1020) @(negedge clk);
    chk("R5 pre-carry lo", cnt_lo, 255);
    chk("R5 pre-carry hi", cnt_hi, 0);
    repeat (4) @(negedge clk);
    chk("R5 carry lo", cnt_lo, 0);
    chk("R5 carry hi", cnt_hi, 1);

    // R7: sampling of the event level on slow ticks
    tick_per = 8;
    setup(3, 0, 8'hFF, 8'hFF);
    repeat (20) @(negedge clk);
    @(posedge clk iff tick);
    @(negedge clk);
    evt_in = 1'b1;
    @(negedge clk);
    evt_in = 1'b0;
    repeat (20) @(negedge clk);
    chk("R7 short pulse missed", cnt_lo, 0);
    evt_in = 1'b1;
    repeat (20) @(negedge clk);
    evt_in = 1'b0;
    repeat (20) @(negedge clk);
    chk("R7 long pulse counted once", cnt_lo, 1);
    evt_in = 1'b1;
    repeat (12) @(negedge clk);
    evt_in = 1'b0;
    repeat (20) @(negedge clk);
    chk("R7 R6 second event", cnt_lo, 2);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule